// File: doc/BRIEF.md
# Configurable Wait-State Access Timer

This block works out how many bus cycles one access to a slow external space costs, then counts that many cycles and raises a one-cycle ready strobe. The space is split into three address regions. The first is a peripheral region that holds two mirrored windows, and each window has its own timing. The second is a cartridge-style ROM region. The third is a cartridge RAM region. An 8-bit control register selects the nonsequential and sequential costs. For each request, the block also decides whether the access counts as sequential. It bases that decision on a DMA burst flag, and in the ROM region it also uses the position of the halfword inside a 0x20000-byte block.

The address input is ADDR_W bits wide (28 by default). Bits [ADDR_W-1:ADDR_W-2] select the region: 00 is the peripheral region, 01 is the ROM region, and 10 or 11 is the cartridge RAM region. Inside the peripheral region, address bit 15 selects window 1 (offset 0x008000). When that bit is clear, the access goes to window 0 (offset 0x000000). No other low bit affects the cost, so the two windows mirror the same space. The request logic is a two-state machine with the states IDLE and WAIT. The transitions are:
- IDLE to WAIT when a request is accepted.
- WAIT to WAIT while the counter runs down.
- WAIT to WAIT with a reload, when ready coincides with a new request.
- WAIT to IDLE when ready is raised and no request is pending.

Top module: `waitstate_timer`

## Requirements
- R1: Control bits [1:0] give the window-0 nonsequential cost: 0→10, 1→8, 2→6, 3→18 cycles.
- R2: Control bit 2 gives the window-0 sequential cost: 6 cycles when clear, 4 when set.
- R3: Control bits [4:3] give the window-1 nonsequential cost, using the same four values as R1.
- R4: Control bit 5 gives the window-1 sequential cost: 10 cycles when clear, 4 when set.
- R5: In the peripheral region, address bit 15 alone selects the window (set means window 1). All other low address bits have no effect on the cost.
- R6: In the ROM region, control bits [7:6] give the nonsequential cost, using the R1 values. The sequential cost is ROM_SEQ_CYC (6 by default). A burst access is sequential unless address bits [16:1] are all ones, which marks the last halfword of a 0x20000-byte block.
- R7: A cartridge RAM access (address bit 27 set) always costs the ROM nonsequential cost, even when the burst flag is high.
- R8: With dma_burst low, every access in every region uses the nonsequential cost.
- R9: ready is a one-cycle pulse. It is high in cycle cost−1, where cycle 0 is the cycle in which the request was accepted. The cost output equals the access's cost during that cycle.
- R10: A request is accepted when the block is idle or when ready is high. A request held high while the block is busy and ready is low has no effect on the access in flight.
- R11: A control write affects only requests accepted after the write's clock edge. A request accepted on the same edge as the write, or an access already in flight, keeps the old costs.
- R12: After reset, the block is idle, ready is low and the control register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | CFG_W | Control register write data |
| req | input | 1 | Access request strobe |
| addr | input | ADDR_W | Access address |
| dma_burst | input | 1 | Access continues a linear DMA burst |
| ready | output | 1 | One-cycle completion strobe |
| cost | output | 5 | Cycle cost of the completing access |

## Verification
A wrong count or state in the countdown shows up at the ports as a ready pulse that comes too early or too late. The error is visible within at most 18 cycles of the request. It can also show up as a doubled pulse or as a missing pulse. A wrong region or sequential decision, or a wrong table entry, shows up as a wrong cost value and a wrong latency on the very next access to that region. For this reason the bench sweeps every control value against both windows with the burst flag low and high. It also probes the ROM block edges and the cases where a write and an access fall on the same edge.

// File: rtl/wst_pkg.sv
package wst_pkg;
    localparam int COST_W = 5;

    typedef logic [COST_W-1:0] cost_t;

    typedef enum logic [1:0] {
        RG_PERIPH = 2'b00,
        RG_ROM    = 2'b01,
        RG_RAM    = 2'b10
    } region_e;

    typedef struct packed {
        cost_t win0_n;
        cost_t win0_s;
        cost_t win1_n;
        cost_t win1_s;
        cost_t rom_n;
        cost_t rom_s;
    } cost_set_t;

    // two-bit selector to nonsequential cycle count
    function automatic cost_t nseq_lut(input logic [1:0] sel);
        cost_t r;
        unique case (sel)
            2'd0: r = cost_t'(10);
            2'd1: r = cost_t'(8);
            2'd2: r = cost_t'(6);
            default: r = cost_t'(18);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/wst_cfg_reg.sv
module wst_cfg_reg
    import wst_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int ROM_SEQ_CYC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cost_set_t        costs
);
    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= wdata;
    end

    always_comb begin
        costs.win0_n = nseq_lut(cfg_q[1:0]);
        costs.win0_s = cfg_q[2] ? cost_t'(4) : cost_t'(6);
        costs.win1_n = nseq_lut(cfg_q[4:3]);
        costs.win1_s = cfg_q[5] ? cost_t'(4) : cost_t'(10);
        costs.rom_n  = nseq_lut(cfg_q[7:6]);
        costs.rom_s  = cost_t'(ROM_SEQ_CYC);
    end

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/wst_classify.sv
module wst_classify
    import wst_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int WIN_BIT   = 15,
    parameter int BLOCK_BIT = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst,
    input  cost_set_t         costs,
    output cost_t             cost,
    output logic              seq
);
    region_e region;
    logic    block_end;
    logic    unused_addr;

    assign unused_addr = ^addr;

    always_comb begin
        unique case (addr[ADDR_W-1:ADDR_W-2])
            2'b00:   region = RG_PERIPH;
            2'b01:   region = RG_ROM;
            default: region = RG_RAM;
        endcase
    end

    assign block_end = &addr[BLOCK_BIT-1:1];

    always_comb begin
        seq  = 1'b0;
        cost = costs.rom_n;
        unique case (region)
            RG_PERIPH: begin
                seq = burst;
                if (addr[WIN_BIT]) cost = burst ? costs.win1_s : costs.win1_n;
                else               cost = burst ? costs.win0_s : costs.win0_n;
            end
            RG_ROM: begin
                seq  = burst && !block_end;
                cost = seq ? costs.rom_s : costs.rom_n;
            end
            default: begin
                seq  = 1'b0;
                cost = costs.rom_n;
            end
        endcase
    end

    // R7
    ram_nseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_RAM) |-> (!seq && cost == costs.rom_n));
    // R6
    block_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_ROM && block_end) |-> !seq);
    // R8
    burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !burst |-> !seq);
endmodule

// File: rtl/wst_countdown.sv
module wst_countdown
    import wst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  cost_t cost_in,
    output logic  ready,
    output cost_t cost_o
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;

    st_e   st_q, st_d;
    cost_t cnt_q, cnt_d;
    cost_t cost_q, cost_d;
    logic  accept;

    // output process
    always_comb begin
        ready  = (st_q == ST_WAIT) && (cnt_q == '0);
        cost_o = cost_q;
        accept = req && ((st_q == ST_IDLE) || ready);
    end

    // next-state process
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        cost_d = cost_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d   = ST_WAIT;
                    cnt_d  = cost_in - cost_t'(2);
                    cost_d = cost_in;
                end
            end
            ST_WAIT: begin
                if (ready) begin
                    if (accept) begin
                        cnt_d  = cost_in - cost_t'(2);
                        cost_d = cost_in;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - cost_t'(1);
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            cost_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            cost_q <= cost_d;
        end
    end

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !ready) |=> (st_q == ST_WAIT && cnt_q == $past(cnt_q) - cost_t'(1)));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !ready) |=> $stable(cost_q));
    // R9
    cost_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (cost_in >= cost_t'(4)));
endmodule

// File: rtl/waitstate_timer.sv
module waitstate_timer
    import wst_pkg::*;
#(
    parameter int ADDR_W      = 28,
    parameter int CFG_W       = 8,
    parameter int ROM_SEQ_CYC = 6,
    parameter int WIN_BIT     = 15,
    parameter int BLOCK_BIT   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dma_burst,
    output logic              ready,
    output logic [4:0]        cost
);
    cost_set_t costs;
    cost_t     acc_cost;
    cost_t     done_cost;
    logic      acc_seq;

    wst_cfg_reg #(.CFG_W(CFG_W), .ROM_SEQ_CYC(ROM_SEQ_CYC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .costs(costs)
    );

    wst_classify #(.ADDR_W(ADDR_W), .WIN_BIT(WIN_BIT), .BLOCK_BIT(BLOCK_BIT)) u_cls (
        .clk(clk), .rst_n(rst_n), .addr(addr), .burst(dma_burst),
        .costs(costs), .cost(acc_cost), .seq(acc_seq)
    );

    wst_countdown u_cnt (
        .clk(clk), .rst_n(rst_n), .req(req), .cost_in(acc_cost),
        .ready(ready), .cost_o(done_cost)
    );

    assign cost = done_cost;

    // R8
    seq_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_seq && addr[ADDR_W-1:ADDR_W-2] == 2'b00) |-> (acc_cost <= cost_t'(10)));
endmodule

// File: tb/sim_waitstate_timer.sv
module sim_waitstate_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        req = 1'b0;
    logic [27:0] addr = '0;
    logic        dma_burst = 1'b0;
    logic        ready;
    logic [4:0]  cost;

    int checks = 0;
    int fails = 0;
    logic [7:0] cfg_model = '0;

    waitstate_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .addr(addr), .dma_burst(dma_burst), .ready(ready), .cost(cost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lut(input logic [1:0] s);
        case (s)
            2'd0: return 10;
            2'd1: return 8;
            2'd2: return 6;
            default: return 18;
        endcase
    endfunction

    function automatic int exp_cost(input logic [7:0] c, input logic [27:0] a, input logic b);
        if (a[27]) return lut(c[7:6]);
        if (a[26]) return (b && !(&a[16:1])) ? 6 : lut(c[7:6]);
        if (a[15]) return b ? (c[5] ? 4 : 10) : lut(c[4:3]);
        return b ? (c[2] ? 4 : 6) : lut(c[1:0]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_model = v;
    endtask

    task automatic access(input logic [27:0] a, input logic b, input string tag);
        int n;
        int e;
        e = exp_cost(cfg_model, a, b);
        @(negedge clk);
        req = 1'b1; addr = a; dma_burst = b; n = 0;
        do begin
            @(negedge clk);
            req = 1'b0; n++;
        end while (!ready && n < 40);
        check(n == e - 1, {tag, " latency"}, n, e - 1);
        check(int'(cost) == e, {tag, " cost"}, int'(cost), e);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [27:0] a0;
        logic [27:0] a1;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R12 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b0, "R12 ready after reset", int'(ready), 0);
        access(28'h0000100, 1'b0, "R12 default cost");

        // sweep all window fields, R1 R2 R3 R4 R5 R8
        for (int c = 0; c < 64; c++) begin
            cfg_write({c[1:0], c[5:0]});
            a0 = (28'(c) * 28'h0013A6) & 28'h03FF7FFE;
            a1 = a0 | 28'h0008000;
            access(a0, 1'b0, "R1 win0 nonseq");
            access(a0, 1'b1, "R2 win0 seq");
            access(a1, 1'b0, "R3 win1 nonseq");
            access(a1, 1'b1, "R4 win1 seq");
            access(a1 ^ 28'h0003F00, 1'b1, "R5 mirror");
        end

        // ROM and RAM regions, R6 R7 R8
        for (int r = 0; r < 4; r++) begin
            cfg_write({r[1:0], 6'b0});
            access(28'h4000100, 1'b0, "R8 rom nonburst");
            access(28'h4000100, 1'b1, "R6 rom burst");
            access(28'h401FFFE, 1'b1, "R6 rom block end");
            access(28'h403FFFE, 1'b1, "R6 rom second block end");
            access(28'h4020000, 1'b1, "R6 rom block start");
            access(28'h401FFFC, 1'b1, "R6 rom before end");
            access(28'h8000010, 1'b1, "R7 ram burst");
            access(28'hC01FFFE, 1'b0, "R7 ram nonburst");
        end

        // R11 write on same edge as request
        cfg_write(8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h03; req = 1'b1; addr = 28'h0000200; dma_burst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            cfg_we = 1'b0; req = 1'b0; n++;
        end while (!ready && n < 40);
        check(n == 9, "R11 same-edge latency", n, 9);
        check(cost == 5'd10, "R11 same-edge cost", int'(cost), 10);
        cfg_model = 8'h03;
        access(28'h0000200, 1'b0, "R11 new value");

        // R11 write during flight
        @(negedge clk);
        req = 1'b1; addr = 28'h0000200; dma_burst = 1'b0; n = 0;
        do begin
            @(negedge clk);
            req = 1'b0; n++;
            cfg_we = (n == 3);
            cfg_wdata = 8'h00;
        end while (!ready && n < 40);
        cfg_we = 1'b0;
        check(n == 17, "R11 in-flight latency", n, 17);
        check(cost == 5'd18, "R11 in-flight cost", int'(cost), 18);
        cfg_model = 8'h00;
        access(28'h0000200, 1'b0, "R11 after flight");

        // R10 busy request ignored, then back-to-back accept
        cfg_write(8'h24);
        @(negedge clk);
        req = 1'b1; addr = 28'h0000040; dma_burst = 1'b0;
        @(negedge clk);
        addr = 28'h0008040; dma_burst = 1'b1; n = 1;
        while (!ready && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == 9, "R10 busy ignored latency", n, 9);
        check(cost == 5'd10, "R10 busy ignored cost", int'(cost), 10);
        n = 0;
        do begin
            @(negedge clk);
            req = 1'b0; n++;
        end while (!ready && n < 40);
        check(n == 3, "R10 back-to-back latency", n, 3);
        check(cost == 5'd4, "R10 back-to-back cost", int'(cost), 4);
        @(negedge clk);
        check(ready == 1'b0, "R9 single pulse", int'(ready), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule